// File: doc/BRIEF.md
# SDRAM Read Latency and Byte Mask Timing Path

This block sits between the storage array of a synchronous DRAM model and its data pins. It delays read data by the programmed CAS latency, either two or three clocks. It also applies the per-byte mask pins with two different timings. On reads, the mask is a delayed output enable that floats a byte lane. On writes, the mask acts in the same cycle and stops that byte from being written. Storage itself lives outside the block.

Reads leave the array as one beat per cycle. The beat is marked by `rd_valid` with its data on `rd_data`. The chosen latency is captured with the beat when it enters the pipe. Writes arrive the same way on `wr_valid`/`wr_data` and leave as registered data with per-byte strobes. Neither stream has back-pressure, so there is no ready signal. The only way to stall is `clk_en` low, which holds every stage.

A read accepted at rising edge k is driven after edge k+CL-1, so a consumer samples it at edge k+CL. A mask sampled at edge j governs the read beat driven after edge j+1, which is sampled at edge j+2.

Top module: `rdq_timing_path`

## Requirements
- R1: With `cas_lat3`=1, a read accepted at enabled edge k is on `dq_out` after enabled edge k+2. With `cas_lat3`=0, it is there after enabled edge k+1.
- R2: The latency is fixed when the read is accepted. A later change of `cas_lat3` does not move a beat that is already in flight.
- R3: The mask sampled at enabled edge j sets `dq_oe` after edge j+1: a mask bit of 1 clears that lane's enable, and a 0 sets it while a read beat is being driven.
- R4: `dq_mask[0]`/`dq_oe[0]`/`wr_strobe[0]` belong to data bits 7:0, and `dq_mask[1]`/`dq_oe[1]`/`wr_strobe[1]` belong to bits 15:8.
- R5: When no read beat is being driven, `dq_oe` is 0 whatever the mask.
- R6: A lane whose `dq_oe` bit is 0 drives zeros on its `dq_out` bits.
- R7: After enabled edge j, `wr_data_out` equals the `wr_data` sampled at j. `wr_strobe` equals the inverse of the mask sampled at that same edge when `wr_valid` was 1, and 0 otherwise.
- R8: While `clk_en` is 0, every output holds its value and all other inputs are ignored. Flow resumes where it stopped.
- R9: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Stage enable; low freezes the block |
| cas_lat3 | input | 1 | 1 selects latency 3, 0 selects latency 2 |
| rd_valid | input | 1 | Read beat from the array is valid |
| rd_data | input | 16 | Read beat data |
| wr_valid | input | 1 | Write beat is valid |
| wr_data | input | 16 | Write beat data from the pins |
| dq_mask | input | 2 | Byte masks, bit 0 lower byte, bit 1 upper byte |
| dq_out | output | 16 | Read data toward the pins |
| dq_oe | output | 2 | Per-byte output enable |
| wr_strobe | output | 2 | Per-byte write strobe to the array |
| wr_data_out | output | 16 | Registered write data to the array |

## Verification
The assertions assume the controller never lets a read with latency two enter when the previous enabled edge accepted a read with latency three. Both beats would otherwise land in the same stage. The assertions also assume the single mask pin serves reads and writes at once, with each interpretation picked by its own timing. The stimulus sweeps all mask values against every read, write and enable pattern and flips the latency every fifty cycles. It forces `rd_valid` low on any cycle that would break the collision rule, so in-flight beats of both latencies still overlap a switch.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  typedef enum logic {
    LAT_TWO   = 1'b0,
    LAT_THREE = 1'b1
  } cas_lat_e;

  localparam int LANE_BITS = 8;
endpackage

// File: rtl/rdq_latency_pipe.sv
module rdq_latency_pipe
  import rdq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  cas_lat_e          lat_sel,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data
);
  logic              early_v;
  logic [DATA_W-1:0] early_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_v    <= 1'b0;
      early_d    <= '0;
      beat_valid <= 1'b0;
      beat_data  <= '0;
    end else if (en) begin
      early_v <= in_valid && (lat_sel == LAT_THREE);
      early_d <= in_data;
      if (early_v) begin
        beat_valid <= 1'b1;
        beat_data  <= early_d;
      end else begin
        beat_valid <= in_valid && (lat_sel == LAT_TWO);
        beat_data  <= in_data;
      end
    end
  end

  assert_short_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid && lat_sel == LAT_TWO && !early_v)
      |=> (beat_valid && beat_data == $past(in_data)));

  assert_inflight_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && early_v) |=> (beat_valid && beat_data == $past(early_d)));
endmodule

// File: rtl/rdq_read_gate.sv
module rdq_read_gate #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [LANES-1:0]  mask,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe
);
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  oe_nx;
  logic [DATA_W-1:0] out_nx;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign oe_nx[l] = beat_valid && !mask_q[l];
    assign out_nx[l*LANE_W +: LANE_W] = oe_nx[l] ? beat_data[l*LANE_W +: LANE_W] : '0;

    assert_dark_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe[l] |-> (dq_out[l*LANE_W +: LANE_W] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dq_oe  <= '0;
      dq_out <= '0;
    end else if (en) begin
      mask_q <= mask;
      dq_oe  <= oe_nx;
      dq_out <= out_nx;
    end
  end

  assert_idle_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !beat_valid) |=> (dq_oe == '0));

  assert_mask_two_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && beat_valid) |=> (dq_oe == ~$past(mask_q)));
endmodule

// File: rtl/rdq_write_gate.sv
module rdq_write_gate #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  mask,
  output logic [LANES-1:0]  strobe,
  output logic [DATA_W-1:0] data_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe   <= '0;
      data_out <= '0;
    end else if (en) begin
      strobe   <= in_valid ? ~mask : '0;
      data_out <= in_data;
    end
  end

  assert_write_same_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid) |=> (strobe == ~$past(mask) && data_out == $past(in_data)));

  assert_no_write_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !in_valid) |=> (strobe == '0));
endmodule

// File: rtl/rdq_timing_path.sv
module rdq_timing_path
  import rdq_pkg::*;
#(
  parameter int LANE_W = LANE_BITS,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              cas_lat3,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  dq_mask,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic [LANES-1:0]  wr_strobe,
  output logic [DATA_W-1:0] wr_data_out
);
  cas_lat_e          lat_sel;
  logic              beat_valid;
  logic [DATA_W-1:0] beat_data;

  assign lat_sel = cas_lat3 ? LAT_THREE : LAT_TWO;

  rdq_latency_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (clk_en),
    .lat_sel    (lat_sel),
    .in_valid   (rd_valid),
    .in_data    (rd_data),
    .beat_valid (beat_valid),
    .beat_data  (beat_data)
  );

  rdq_read_gate #(.LANE_W(LANE_W), .LANES(LANES)) u_rgate (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (clk_en),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .mask       (dq_mask),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe)
  );

  rdq_write_gate #(.LANE_W(LANE_W), .LANES(LANES)) u_wgate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (clk_en),
    .in_valid (wr_valid),
    .in_data  (wr_data),
    .mask     (dq_mask),
    .strobe   (wr_strobe),
    .data_out (wr_data_out)
  );

  assert_freeze_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(dq_out) && $stable(dq_oe) && $stable(wr_strobe)
                 && $stable(wr_data_out)));
endmodule

// File: tb/rdq_timing_path_tb.sv
module rdq_timing_path_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        cas_lat3 = 1'b0;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  dq_mask = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [1:0]  wr_strobe;
  logic [15:0] wr_data_out;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit was_frozen = 0;

  logic        sv [0:NCYC+4];
  logic [15:0] sd [0:NCYC+4];
  logic [1:0]  mh [0:NCYC+4];
  logic        wv [0:NCYC+4];
  logic [15:0] wd [0:NCYC+4];

  always #(CLK_PERIOD/2) clk = ~clk;

  rdq_timing_path u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cas_lat3(cas_lat3),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_data(wr_data), .dq_mask(dq_mask), .dq_out(dq_out), .dq_oe(dq_oe),
    .wr_strobe(wr_strobe), .wr_data_out(wr_data_out)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s n=%0d actual=%h expected=%h", tag, n, act, exp);
    end
  endtask

  task automatic compare();
    logic [1:0]  eoe;
    logic [15:0] eout;
    logic [1:0]  estb;
    logic [15:0] ewd;
    string rt;
    if (n == 0) begin
      eoe = '0; eout = '0; estb = '0; ewd = '0;
    end else begin
      eoe  = sv[n] ? ~mh[n-1] : 2'b00;
      eout = {eoe[1] ? sd[n][15:8] : 8'h00, eoe[0] ? sd[n][7:0] : 8'h00};
      estb = wv[n] ? ~mh[n] : 2'b00;
      ewd  = wd[n];
    end
    if (n == 0) rt = "R9";
    else if (was_frozen) rt = "R8";
    else rt = "";
    check(dq_oe == eoe, {rt, sv[n] ? " R3 R4 oe" : " R5 oe"}, {14'd0, dq_oe}, {14'd0, eoe});
    check(dq_out == eout, {rt, " R1 R2 R6 dq_out"}, dq_out, eout);
    check(wr_strobe == estb, {rt, " R7 R4 strobe"}, {14'd0, wr_strobe}, {14'd0, estb});
    check(wr_data_out == ewd, {rt, " R7 wdata"}, wr_data_out, ewd);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit prev_l3rd = 0;
    for (int k = 0; k <= NCYC + 4; k++) begin
      sv[k] = 1'b0; sd[k] = '0; mh[k] = '0; wv[k] = 1'b0; wd[k] = '0;
    end
    repeat (4) @(negedge clk);
    check(dq_oe == 2'b00 && wr_strobe == 2'b00, "R9 reset enables",
          {12'd0, dq_oe, wr_strobe}, 16'h0000);
    check(dq_out == '0 && wr_data_out == '0, "R9 reset data",
          dq_out | wr_data_out, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < NCYC; i++) begin
      compare();
      clk_en   = !(((i % 11) == 5) || ((i % 13) == 7));
      cas_lat3 = ((i / 50) % 2) == 1;
      rd_valid = ((i % 5) != 2) && (((i / 3) % 4) != 3);
      if (!cas_lat3 && prev_l3rd) rd_valid = 1'b0;
      dq_mask  = 2'((i + i / 4) % 4);
      rd_data  = 16'(i * 40503 + 4660);
      wr_valid = (i % 3) != 0;
      wr_data  = 16'(~(i * 2749) ^ i);
      if (clk_en) begin
        mh[n+1] = dq_mask;
        if (rd_valid) begin
          sv[n + 1 + (cas_lat3 ? 2 : 1)] = 1'b1;
          sd[n + 1 + (cas_lat3 ? 2 : 1)] = rd_data;
        end
        wv[n+1] = wr_valid;
        wd[n+1] = wr_data;
        prev_l3rd = rd_valid && cas_lat3;
      end
      @(negedge clk);
      was_frozen = !clk_en;
      if (clk_en) n++;
    end
    compare();
    finish_run();
  end
endmodule